// File: doc/BRIEF.md
# Dead-Band Heater and Fan Sequencer

This block is a clocked controller for a heating element and its circulation fan. Heating is regulated with a dead band. The heater starts when the room is too cold and stops when it is too warm. Between those two limits the current heater state is kept. The fan follows the heater with two separate delays, both counted in clocks. The fan comes on a set number of clocks after the heater starts, and it goes off a set number of clocks after the heater stops.

The two limits come from one of two sources, chosen by a mode input. In comparator mode, two threshold flags arrive from outside. `above_lo` is true above the lower set point, and `above_hi` is true above the upper set point. In numeric mode, the block compares a 4-bit measured temperature against a 4-bit set point, and it applies a fixed band of 2 on either side.

The outputs form the pair [H F] = {`heat`, `fan`}. The four states are:
- 00: idle
- 10: heater on, fan still waiting
- 11: both running
- 01: fan running on after the heater has stopped

Top module: `hvac_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) gives `heat`=0, `fan`=0 and `err`=0 after that edge. It also clears any delay in progress.
- R2: When the too-cold condition holds at a clock edge, `heat` is 1 after that edge. In comparator mode, too-cold means `above_lo`=0 and `above_hi`=0.
- R3: Inside the band, `heat` keeps its value. In comparator mode, the band is `above_lo`=1 and `above_hi`=0.
- R4: When the too-warm condition holds at a clock edge, `heat` is 0 after that edge. In comparator mode, too-warm means `above_lo`=1 and `above_hi`=1.
- R5: `fan` rises exactly ON_DLY clock edges after `heat` rises, provided `heat` stays 1 (default ON_DLY=4). ON_DLY=1 gives a one-clock follow.
- R6: `fan` falls exactly OFF_DLY clock edges after `heat` falls, provided `heat` stays 0 (default OFF_DLY=2).
- R7: If too-cold returns while the fan run-on is still counting, `heat` returns to 1 on the next edge and `fan` stays 1 without a gap.
- R8: In comparator mode, the combination `above_lo`=0 and `above_hi`=1 is invalid. On an edge with this input, the outputs and the delay progress are frozen and `err` is 1 after that edge. At any other edge, `err` is 0 after it.
- R9: In numeric mode (`mode_num`=1):
  - too-cold is `setpt` − `temp` > 2;
  - too-warm is `temp` − `setpt` > 2;
  - the comparison is exact over the full 0..15 range, with no wrap-around;
  - the threshold pins are ignored.
- R10: If the heater stops before its fan delay has run out, the fan never starts and the state returns to idle.
- R11: `fan` only rises while `heat` is 1, and only falls while `heat` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_num | input | 1 | 0 = comparator mode, 1 = numeric mode |
| above_lo | input | 1 | True above the lower set point (comparator mode) |
| above_hi | input | 1 | True above the upper set point (comparator mode) |
| setpt | input | 4 | Set point (numeric mode) |
| temp | input | 4 | Measured temperature (numeric mode) |
| heat | output | 1 | Heater drive (H) |
| fan | output | 1 | Fan drive (F) |
| err | output | 1 | Invalid threshold combination seen at the last edge |

## Verification
Directed sequences set up each state of the cycle in turn and hold the inputs long enough for the delays to run out:
- a cold start, to tell the on-delay apart from an early or late fan;
- a band hold, to tell dead-band behaviour from a simple on/off threshold;
- a warm stop followed by a return to cold during the run-on, to tell the seamless re-entry from a restart through idle;
- a stop during the on-delay;
- the invalid pair in the middle of a delay, to tell whether the counters are frozen;
- numeric inputs at band distance 2 and 3, and at the range limits 0 and 15, to find off-by-one and wrap-around errors.

Random phases with a fixed seed then hold each input pattern for a random number of clocks, in both modes, so that the delays get cut off at every point.

// File: rtl/hvac_seq.sv
module hvac_seq #(
  parameter int TW      = 4,
  parameter int BAND    = 2,
  parameter int ON_DLY  = 4,
  parameter int OFF_DLY = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode_num,
  input  logic          above_lo,
  input  logic          above_hi,
  input  logic [TW-1:0] setpt,
  input  logic [TW-1:0] temp,
  output logic          heat,
  output logic          fan,
  output logic          err
);
  localparam int MAXD = (ON_DLY > OFF_DLY) ? ON_DLY : OFF_DLY;
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam int XW   = TW + 2;

  typedef enum logic [1:0] {
    IDLE   = 2'b00,
    WARMUP = 2'b10,
    RUN    = 2'b11,
    COOL   = 2'b01
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;

  logic [XW-1:0] sp_x, t_x;
  assign sp_x = XW'(setpt);
  assign t_x  = XW'(temp);

  logic n_cold, n_warm, c_cold, c_warm, bad, cold, warm;
  assign n_cold = sp_x > t_x + XW'(BAND);
  assign n_warm = t_x > sp_x + XW'(BAND);
  assign c_cold = !above_lo && !above_hi;
  assign c_warm = above_lo && above_hi;
  assign bad    = !mode_num && !above_lo && above_hi;
  assign cold   = mode_num ? n_cold : c_cold;
  assign warm   = mode_num ? n_warm : c_warm;

  logic on_done, off_done;
  assign on_done  = cnt == CW'(ON_DLY - 1);
  assign off_done = cnt == CW'(OFF_DLY - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= IDLE;
      cnt <= '0;
      err <= 1'b0;
    end else begin
      err <= bad;
      if (!bad) begin
        unique case (st)
          IDLE: begin
            cnt <= '0;
            if (cold) st <= WARMUP;
          end
          WARMUP: begin
            if (warm) begin
              st  <= IDLE;
              cnt <= '0;
            end else if (on_done) begin
              st  <= RUN;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RUN: begin
            cnt <= '0;
            if (warm) st <= COOL;
          end
          COOL: begin
            if (cold) begin
              st  <= RUN;
              cnt <= '0;
            end else if (off_done) begin
              st  <= IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            st  <= IDLE;
            cnt <= '0;
          end
        endcase
      end
    end
  end

  assign heat = st[1];
  assign fan  = st[0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!heat && !fan && !err));

  assert_cold_start_R2: assert property (@(posedge clk) disable iff (rst)
    (cold && !bad) |=> heat);

  assert_band_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!cold && !warm && !bad) |=> $stable(heat));

  assert_warm_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (warm && !bad) |=> !heat);

  assert_reentry_R7: assert property (@(posedge clk) disable iff (rst)
    (!heat && fan && cold && !bad) |=> (heat && fan));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    bad |=> (err && $stable(heat) && $stable(fan)));

  assert_fan_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(fan) |-> heat);

  assert_fan_fall_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(fan) |-> !heat);

  assert_no_early_fan_R10: assert property (@(posedge clk) disable iff (rst)
    (heat && !fan && warm && !bad) |=> (!heat && !fan));
endmodule

// File: tb/hvac_seq_bench.sv
module hvac_seq_bench;
  localparam int CLK_P   = 10;
  localparam int ON_DLY  = 4;
  localparam int OFF_DLY = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_num = 1'b0;
  logic       above_lo = 1'b0;
  logic       above_hi = 1'b0;
  logic [3:0] setpt = 4'd8;
  logic [3:0] temp = 4'd8;
  logic       heat, fan, err;

  hvac_seq #(.TW(4), .BAND(2), .ON_DLY(ON_DLY), .OFF_DLY(OFF_DLY)) u_hvac_seq (
    .clk(clk), .rst(rst), .mode_num(mode_num), .above_lo(above_lo),
    .above_hi(above_hi), .setpt(setpt), .temp(temp),
    .heat(heat), .fan(fan), .err(err)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic m_h = 0, m_f = 0, m_e = 0;
  int hon = 0, hoff = 0;

  function automatic logic want_cold(logic mn, logic lo, logic hi, int sp, int t);
    return mn ? (sp - t > 2) : (!lo && !hi);
  endfunction

  function automatic logic want_warm(logic mn, logic lo, logic hi, int sp, int t);
    return mn ? (t - sp > 2) : (lo && hi);
  endfunction

  task automatic model_edge();
    logic c, w, hn, fn;
    if (rst) begin
      m_h = 0; m_f = 0; m_e = 0; hon = 0; hoff = 0;
    end else if (!mode_num && !above_lo && above_hi) begin
      m_e = 1;
    end else begin
      m_e = 0;
      c = want_cold(mode_num, above_lo, above_hi, int'(setpt), int'(temp));
      w = want_warm(mode_num, above_lo, above_hi, int'(setpt), int'(temp));
      hn = c ? 1'b1 : (w ? 1'b0 : m_h);
      fn = m_f;
      if (hn && !m_h) hon = 0;
      else if (hn && m_h) begin
        if (!m_f) begin hon++; fn = (hon == ON_DLY); end
      end else if (!hn && m_h) hoff = 0;
      else if (m_f) begin hoff++; fn = (hoff != OFF_DLY); end
      m_h = hn; m_f = fn;
    end
  endtask

  task automatic check(string tag);
    checks++;
    if (heat !== m_h || fan !== m_f || err !== m_e) begin
      errors++;
      $display("FAIL %s: got heat=%b fan=%b err=%b, expected heat=%b fan=%b err=%b",
               tag, heat, fan, err, m_h, m_f, m_e);
    end
  endtask

  task automatic step(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic cmp(logic lo, logic hi);
    mode_num = 0; above_lo = lo; above_hi = hi;
  endtask

  task automatic num(int sp, int t);
    mode_num = 1; setpt = 4'(sp); temp = 4'(t);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    rst = 1;
    step("R1", 2);
    rst = 0;
    cmp(1, 0);
    step("R3", 2);
    cmp(0, 0);
    step("R2", 1);
    step("R5", ON_DLY);
    cmp(1, 0);
    step("R3", 3);
    cmp(1, 1);
    step("R4", 1);
    cmp(1, 0);
    step("R6", 1);
    cmp(0, 0);
    step("R7", 3);
    cmp(1, 1);
    step("R6", OFF_DLY + 2);
    cmp(0, 0);
    step("R10", 2);
    cmp(1, 1);
    step("R10", ON_DLY + 2);
    cmp(0, 0);
    step("R2", 2);
    cmp(0, 1);
    step("R8", 3);
    cmp(1, 0);
    step("R5", ON_DLY);
    cmp(1, 1);
    step("R4", 1);
    cmp(0, 1);
    step("R8", 2);
    cmp(1, 0);
    step("R6", OFF_DLY + 1);
    num(8, 6);
    step("R9", 2);
    num(8, 5);
    step("R9", ON_DLY + 1);
    num(8, 10);
    step("R9", 2);
    num(8, 11);
    step("R9", OFF_DLY + 1);
    num(15, 0);
    above_lo = 0; above_hi = 1;
    step("R9", 2);
    num(0, 15);
    step("R9", 3);
    cmp(0, 0);
    step("R2", 3);
    rst = 1;
    step("R1", 1);
    rst = 0;
    cmp(1, 0);
    step("R1", 2);

    void'($urandom(32'd1234));
    for (int k = 0; k < 1500; k++) begin
      int hold = 1 + int'($urandom_range(6));
      if ($urandom_range(1) == 0) begin
        int r = int'($urandom_range(19));
        if (r == 0) cmp(0, 1);
        else if (r < 7) cmp(0, 0);
        else if (r < 13) cmp(1, 0);
        else cmp(1, 1);
        step("R11", hold);
      end else begin
        num(int'($urandom_range(15)), int'($urandom_range(15)));
        above_lo = 1'($urandom_range(1));
        above_hi = 1'($urandom_range(1));
        step("R9", hold);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule